// File: doc/BRIEF.md
# Block I/O Transfer Step Unit

This unit carries out a single step of a byte-wide block transfer between an I/O port and memory, as used by a CPU's repeated-string I/O instructions. In input mode it fetches a byte from the port whose 16-bit address is the byte-count register joined with the port-select register ({B,C}), and stores that byte in memory at the pointer HL. In output mode it reads the byte at HL, decrements the count B, and sends the byte to the port at {new B, C}. In both modes HL steps by one in the chosen direction, B is decremented, and an internal memory-pointer value is derived from the port address plus or minus one.

The step also produces the flag byte that these instructions leave behind. Sign, zero and the two undocumented copy bits reflect the new count. The subtract flag mirrors bit 7 of the moved byte. Carry, half-carry and parity come from an auxiliary 8-bit sum. That sum adds the byte either to the adjusted port-select value or to the low byte of the updated pointer. A caller pulses `start` with the register values, serves the memory and I/O requests with an acknowledge, and collects the results when `done` pulses.

Top module: `blkio_step`

## Requirements
- R1: A `start` pulse while idle latches all register inputs and begins a step. In the first cycle of the step, `bus_addr` carries `reg_ir` with neither `mem_req` nor `io_req` asserted. A `start` that arrives while a step is running is ignored.
- R2: Input mode (`mode_out`=0) first performs an I/O read (`io_req`=1, `bus_we`=0) at address {B,C}. It then performs a memory write (`mem_req`=1, `bus_we`=1) at HL with the byte that was read.
- R3: Output mode (`mode_out`=1) first performs a memory read at HL. It then performs an I/O write at address {B-1,C} with that byte.
- R4: A request stays asserted, with a stable address, until the cycle in which `bus_ack` is high. `mem_req` and `io_req` are never high together.
- R5: `new_b` is B-1 modulo 256. `new_hl` is HL+1 when `dir_dec`=0 and HL-1 when `dir_dec`=1, modulo 65536.
- R6: `new_memptr` is {B,C}±1 in input mode and {B-1,C}±1 in output mode, with the sign chosen by `dir_dec` and the result taken modulo 65536.
- R7: In `new_flags`, bit 7 is new B bit 7, bit 6 is high exactly when new B is zero, bit 5 is new B bit 5, bit 3 is new B bit 3, and bit 1 is bit 7 of the transferred byte.
- R8: The auxiliary sum k is the byte plus (C+1) in input/increment mode, the byte plus (C-1) in input/decrement mode, and the byte plus the low byte of the new HL in output mode. A carry out of bit 7 of k sets both bit 4 and bit 0 of `new_flags`.
- R9: Bit 2 of `new_flags` is high when ((k AND 7) XOR new B) has an even number of ones.
- R10: `done` is high for exactly one cycle per step. All result outputs, including `xfer_byte`, change only in that cycle and then hold. A `start` given in the `done` cycle begins the next step.
- R11: Reset clears `done`, both requests, and all result outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one transfer step |
| mode_out | input | 1 | 0 = port to memory, 1 = memory to port |
| dir_dec | input | 1 | 0 = pointer increments, 1 = pointer decrements |
| reg_b | input | 8 | Byte count, high half of the port address |
| reg_c | input | 8 | Port select, low half of the port address |
| reg_hl | input | 16 | Memory pointer |
| reg_ir | input | 16 | Value driven during the idle address cycle |
| bus_addr | output | 16 | Address for memory or I/O |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| mem_req | output | 1 | Memory request |
| io_req | output | 1 | I/O request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_ack | input | 1 | Completes the current request |
| done | output | 1 | One-cycle completion pulse |
| new_b | output | 8 | Decremented count |
| new_hl | output | 16 | Stepped pointer |
| new_memptr | output | 16 | Port address ±1 |
| new_flags | output | 8 | Resulting flag byte |
| xfer_byte | output | 8 | Byte moved by the step |

## Verification
Two functions can fall in the same cycle: the completion of one step, and the acceptance of the next `start` together with the end of the second bus handshake. The bench drives `start` with fresh register values in the very cycle `done` is seen. It also runs zero-wait acknowledges, so a request is granted in the cycle it first appears. While the new step runs, the bench checks every cycle that the earlier results stay put. When the new step completes, it checks that the results are exactly the new step's values. A stray `start` in mid-step, carrying a different count, must leave both the bus traffic and the results of the running step unchanged.

// File: rtl/blkio_pkg.sv
package blkio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_IRC,
    ST_XFER1,
    ST_XFER2
  } blkio_st_t;

  // flag byte bit positions (fixed by the consuming register file)
  localparam int FB_SIGN  = 7;
  localparam int FB_ZERO  = 6;
  localparam int FB_CPY5  = 5;
  localparam int FB_HALF  = 4;
  localparam int FB_CPY3  = 3;
  localparam int FB_PAR   = 2;
  localparam int FB_SUB   = 1;
  localparam int FB_CARRY = 0;
endpackage

// File: rtl/blkio_ctl.sv
module blkio_ctl
  import blkio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  mode_out,
  input  logic                  dir_dec,
  input  logic [DATA_W-1:0]     reg_b,
  input  logic [DATA_W-1:0]     reg_c,
  input  logic [2*DATA_W-1:0]   reg_hl,
  input  logic [2*DATA_W-1:0]   reg_ir,
  input  logic [DATA_W-1:0]     bus_rdata,
  input  logic                  bus_ack,
  output logic [2*DATA_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]     bus_wdata,
  output logic                  mem_req,
  output logic                  io_req,
  output logic                  bus_we,
  output logic                  busy,
  output logic                  fin,
  output logic                  l_mode,
  output logic                  l_dir,
  output logic [DATA_W-1:0]     l_b,
  output logic [DATA_W-1:0]     l_c,
  output logic [2*DATA_W-1:0]   l_hl,
  output logic [DATA_W-1:0]     l_byte
);
  localparam int ADDR_W = 2 * DATA_W;

  blkio_st_t         st;
  logic [ADDR_W-1:0] l_ir;
  logic [DATA_W-1:0] b_dec;

  assign b_dec = l_b - 1'b1;
  assign busy  = (st != ST_IDLE);
  assign fin   = (st == ST_XFER2) && bus_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      l_mode <= 1'b0;
      l_dir  <= 1'b0;
      l_b    <= '0;
      l_c    <= '0;
      l_hl   <= '0;
      l_ir   <= '0;
      l_byte <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_IRC;
          l_mode <= mode_out;
          l_dir  <= dir_dec;
          l_b    <= reg_b;
          l_c    <= reg_c;
          l_hl   <= reg_hl;
          l_ir   <= reg_ir;
        end
        ST_IRC:  st <= ST_XFER1;
        ST_XFER1: if (bus_ack) begin
          l_byte <= bus_rdata;
          st     <= ST_XFER2;
        end
        ST_XFER2: if (bus_ack) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // bus phase decode: first transfer reads, second writes
  always_comb begin
    bus_addr  = l_ir;
    bus_wdata = '0;
    mem_req   = 1'b0;
    io_req    = 1'b0;
    bus_we    = 1'b0;
    case (st)
      ST_XFER1: begin
        bus_addr = l_mode ? l_hl : {l_b, l_c};
        mem_req  = l_mode;
        io_req   = !l_mode;
      end
      ST_XFER2: begin
        bus_addr  = l_mode ? {b_dec, l_c} : l_hl;
        bus_wdata = l_byte;
        bus_we    = 1'b1;
        mem_req   = !l_mode;
        io_req    = l_mode;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/blkio_flags.sv
module blkio_flags
  import blkio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                mode_out,
  input  logic                dir_dec,
  input  logic [DATA_W-1:0]   b_old,
  input  logic [DATA_W-1:0]   c_val,
  input  logic [2*DATA_W-1:0] hl_old,
  input  logic [DATA_W-1:0]   xbyte,
  output logic [DATA_W-1:0]   b_nx,
  output logic [2*DATA_W-1:0] hl_nx,
  output logic [2*DATA_W-1:0] mp_nx,
  output logic [7:0]          flg
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] port_base;
  logic [DATA_W-1:0] c_adj;
  logic [DATA_W-1:0] addend;
  logic [DATA_W:0]   ksum;
  logic [DATA_W-1:0] par_src;
  logic              kcarry;

  assign b_nx      = b_old - 1'b1;
  assign hl_nx     = dir_dec ? hl_old - 1'b1 : hl_old + 1'b1;
  assign port_base = mode_out ? {b_nx, c_val} : {b_old, c_val};
  assign mp_nx     = dir_dec ? port_base - 1'b1 : port_base + 1'b1;

  assign c_adj   = dir_dec ? c_val - 1'b1 : c_val + 1'b1;
  assign addend  = mode_out ? hl_nx[DATA_W-1:0] : c_adj;
  assign ksum    = {1'b0, xbyte} + {1'b0, addend};
  assign kcarry  = ksum[DATA_W];
  assign par_src = {{(DATA_W-3){1'b0}}, ksum[2:0]} ^ b_nx;

  always_comb begin
    flg           = '0;
    flg[FB_SIGN]  = b_nx[DATA_W-1];
    flg[FB_ZERO]  = (b_nx == '0);
    flg[FB_CPY5]  = b_nx[5];
    flg[FB_CPY3]  = b_nx[3];
    flg[FB_HALF]  = kcarry;
    flg[FB_CARRY] = kcarry;
    flg[FB_PAR]   = ~^par_src;
    flg[FB_SUB]   = xbyte[DATA_W-1];
  end
endmodule

// File: rtl/blkio_step.sv
module blkio_step
  import blkio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_out,
  input  logic              dir_dec,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [DATA_W-1:0] reg_c,
  input  logic [ADDR_W-1:0] reg_hl,
  input  logic [ADDR_W-1:0] reg_ir,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              mem_req,
  output logic              io_req,
  output logic              bus_we,
  input  logic              bus_ack,
  output logic              done,
  output logic [DATA_W-1:0] new_b,
  output logic [ADDR_W-1:0] new_hl,
  output logic [ADDR_W-1:0] new_memptr,
  output logic [7:0]        new_flags,
  output logic [DATA_W-1:0] xfer_byte
);
  logic              busy, fin, l_mode, l_dir;
  logic [DATA_W-1:0] l_b, l_c, l_byte, b_nx;
  logic [ADDR_W-1:0] l_hl, hl_nx, mp_nx;
  logic [7:0]        flg;

  blkio_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .mode_out(mode_out),
    .dir_dec(dir_dec), .reg_b(reg_b), .reg_c(reg_c), .reg_hl(reg_hl),
    .reg_ir(reg_ir), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mem_req(mem_req),
    .io_req(io_req), .bus_we(bus_we), .busy(busy), .fin(fin),
    .l_mode(l_mode), .l_dir(l_dir), .l_b(l_b), .l_c(l_c), .l_hl(l_hl),
    .l_byte(l_byte)
  );

  blkio_flags #(.DATA_W(DATA_W)) u_flags (
    .mode_out(l_mode), .dir_dec(l_dir), .b_old(l_b), .c_val(l_c),
    .hl_old(l_hl), .xbyte(l_byte), .b_nx(b_nx), .hl_nx(hl_nx),
    .mp_nx(mp_nx), .flg(flg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      new_b      <= '0;
      new_hl     <= '0;
      new_memptr <= '0;
      new_flags  <= '0;
      xfer_byte  <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        new_b      <= b_nx;
        new_hl     <= hl_nx;
        new_memptr <= mp_nx;
        new_flags  <= flg;
        xfer_byte  <= l_byte;
      end
    end
  end
endmodule

// File: rtl/blkio_chk.sv
module blkio_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic [ADDR_W-1:0] reg_ir,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              mem_req,
  input logic              io_req,
  input logic              bus_ack,
  input logic              done,
  input logic [DATA_W-1:0] new_b,
  input logic [7:0]        new_flags,
  input logic [ADDR_W-1:0] new_memptr
);
  a_r1_ir_cycle: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (!mem_req && !io_req && bus_addr == $past(reg_ir)));

  a_r4_one_space: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && io_req));

  a_r4_mem_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !bus_ack) |=> (mem_req && $stable(bus_addr)));

  a_r4_io_held: assert property (@(posedge clk) disable iff (rst)
    (io_req && !bus_ack) |=> (io_req && $stable(bus_addr)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_results_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(new_flags) && $stable(new_b) && $stable(new_memptr)));
endmodule

bind blkio_step blkio_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .reg_ir(reg_ir),
  .bus_addr(bus_addr), .mem_req(mem_req), .io_req(io_req),
  .bus_ack(bus_ack), .done(done), .new_b(new_b), .new_flags(new_flags),
  .new_memptr(new_memptr)
);

// File: tb/test_blkio_step.sv
`timescale 1ns/1ps
module test_blkio_step;
  logic        clk = 1'b0, rst = 1'b1;
  logic        start = 0, mode_out = 0, dir_dec = 0;
  logic [7:0]  reg_b = 0, reg_c = 0, bus_rdata = 0, bus_wdata;
  logic [15:0] reg_hl = 0, reg_ir = 0, bus_addr, new_hl, new_memptr;
  logic        mem_req, io_req, bus_we, bus_ack = 0, done;
  logic [7:0]  new_b, new_flags, xfer_byte;

  int checks = 0, errors = 0, cyc = 0, lat = 0, wcnt = 0;
  logic [7:0]  src_data = 0;
  logic [15:0] rd_addr, wr_addr;
  logic        rd_io, wr_io;
  logic [7:0]  wr_data;

  always #2 clk = ~clk;

  blkio_step i_blkio_step (.*);

  // bus responder: acknowledges after lat waiting cycles, logs transfers
  always @(negedge clk) begin
    if (mem_req || io_req) begin
      if (wcnt >= lat) begin
        bus_ack   <= 1'b1;
        bus_rdata <= src_data;
        wcnt      = 0;
        if (bus_we) begin
          wr_addr = bus_addr; wr_data = bus_wdata; wr_io = io_req;
        end else begin
          rd_addr = bus_addr; rd_io = io_req;
        end
      end else begin
        bus_ack <= 1'b0;
        wcnt    = wcnt + 1;
      end
    end else begin
      bus_ack <= 1'b0;
      wcnt    = 0;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  // One step; entered and left at a negedge (left in the done cycle).
  task automatic run_step(input logic m, input logic d, input logic [7:0] b,
                          input logic [7:0] c, input logic [15:0] hl,
                          input logic [7:0] data, input bit poke);
    logic [7:0]  nb, cadj, fl;
    logic [15:0] hlp, mp;
    logic [8:0]  k;
    logic [7:0]  pb, pf;
    logic [15:0] pm;
    int n;
    nb   = b - 8'd1;
    hlp  = d ? hl - 16'd1 : hl + 16'd1;
    mp   = m ? (d ? {nb, c} - 16'd1 : {nb, c} + 16'd1)
             : (d ? {b, c} - 16'd1 : {b, c} + 16'd1);
    cadj = d ? c - 8'd1 : c + 8'd1;
    k    = m ? {1'b0, data} + {1'b0, hlp[7:0]} : {1'b0, data} + {1'b0, cadj};
    fl   = {nb[7], nb == 8'd0, nb[5], k[8], nb[3],
            ~^({5'd0, k[2:0]} ^ nb), data[7], k[8]};
    pb = new_b; pf = new_flags; pm = new_memptr;
    mode_out = m; dir_dec = d; reg_b = b; reg_c = c; reg_hl = hl;
    reg_ir = {b ^ 8'h3c, c}; src_data = data; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    reg_b = b ^ 8'h55;                    // R1: inputs latched at start
    chk("R1", "ir addr", bus_addr, {b ^ 8'h3c, c});
    chk("R1", "no request", {14'd0, mem_req, io_req}, 16'd0);
    n = 0;
    while (!done && n < 40) begin
      chk("R10", "held b/flags", {new_b, new_flags}, {pb, pf});
      chk("R10", "held memptr", new_memptr, pm);
      if (poke && n == 1) begin
        start = 1'b1; mode_out = !m; reg_b = b ^ 8'h0f;   // R1: ignored
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk("R10", "done seen", {15'd0, done}, 16'd1);
    if (m) begin
      chk("R3", "mem read addr", rd_addr, hl);
      chk("R3", "read space", {15'd0, rd_io}, 16'd0);
      chk("R3", "io write addr", wr_addr, {nb, c});
      chk("R3", "write space", {15'd0, wr_io}, 16'd1);
      chk("R3", "write data", {8'd0, wr_data}, {8'd0, data});
    end else begin
      chk("R2", "io read addr", rd_addr, {b, c});
      chk("R2", "read space", {15'd0, rd_io}, 16'd1);
      chk("R2", "mem write addr", wr_addr, hl);
      chk("R2", "write space", {15'd0, wr_io}, 16'd0);
      chk("R2", "write data", {8'd0, wr_data}, {8'd0, data});
    end
    chk("R5", "new b", {8'd0, new_b}, {8'd0, nb});
    chk("R5", "new hl", new_hl, hlp);
    chk("R6", "memptr", new_memptr, mp);
    chk("R7", "s z f5 f3 n", {8'd0, new_flags & 8'hea}, {8'd0, fl & 8'hea});
    chk("R8", "h c", {8'd0, new_flags & 8'h11}, {8'd0, fl & 8'h11});
    chk("R9", "parity", {15'd0, new_flags[2]}, {15'd0, fl[2]});
    chk("R10", "xfer byte", {8'd0, xfer_byte}, {8'd0, data});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset outputs", {done, mem_req, io_req, 13'd0}, 16'd0);
    chk("R11", "reset results", {new_b, new_flags}, 16'd0);
    chk("R11", "reset memptr/hl", new_memptr | new_hl, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    // sweep all modes, directions and counts; data patterns vary k carry
    for (int md = 0; md < 4; md++) begin
      for (int b = 0; b < 256; b++) begin
        for (int dp = 0; dp < 3; dp++) begin
          logic [7:0] dv, cv;
          logic [15:0] hv;
          dv  = (dp == 0) ? 8'(b * 7 + 3) : (dp == 1) ? 8'hff : 8'(b ^ 8'h80);
          cv  = 8'(b * 13 + dp);
          hv  = {8'(b + 5), 8'(255 - b + dp)};
          lat = (b + dp) % 3;
          run_step(md[1], md[0], 8'(b), cv, hv, dv, 1'b0);
          if (b % 2 == 0) @(negedge clk);   // odd b: next start in done cycle
        end
      end
    end
    // corner cases: B 1 -> 0, overflowing k, pointer wrap, zero-wait chaining
    lat = 0;
    run_step(1'b0, 1'b0, 8'h01, 8'hff, 16'hffff, 8'h80, 1'b0);
    run_step(1'b0, 1'b1, 8'h01, 8'h00, 16'h0000, 8'hff, 1'b0);
    run_step(1'b1, 1'b0, 8'h01, 8'h12, 16'h00ff, 8'hc1, 1'b0);
    run_step(1'b1, 1'b1, 8'h00, 8'h00, 16'h0000, 8'h01, 1'b0);
    // start while busy must be ignored
    lat = 2;
    run_step(1'b0, 1'b0, 8'h20, 8'h40, 16'h1234, 8'h5a, 1'b1);
    run_step(1'b1, 1'b1, 8'h81, 8'h7f, 16'h8000, 8'h7e, 1'b1);
    @(negedge clk);
    finish_run();
  end
endmodule